// File: doc/BRIEF.md
# Serial Port Register Bank

This block sits between a CPU's byte-wide I/O bus and the rest of a serial port. It decodes reads and writes to four byte addresses and holds the settings the port runs from: the frame format (mode, parity, stop bits, character size, clock polarity), a 12-bit baud divisor and the word waiting to be sent. The shifters, the baud generator and the interrupt logic are outside this block. They consume its configuration outputs, take the transmit word when `tx_load` pulses, and present the oldest received character on `rx_data`.

The frame-format register and the upper part of the baud divisor share one address. On a write, bit 7 of the data steers the byte. When bit 7 is 1 the byte goes to the format register. When bit 7 is 0 the low nibble goes to the divisor. On a read, the `rd_sel_fmt` input chooses which of the two registers is returned.

Characters of nine bits cross the 8-bit bus in two parts. For transmit, software writes the ninth bit to the control register first and then writes the low byte. The low-byte write captures both parts at once. For receive, software reads the ninth bit first and then the low byte. Reading the low byte pulses `rx_pop`, which may advance the receive buffer to the next character.

Top module: `sport_regfile`

## Requirements
- R1: After reset, the following hold: the format register reads 0x86, `baud_div` is 0, `tx_word` is 0, `tx_load` is low, and the character-size code is 3'b011 with `cfg_char_bits` equal to 8.
- R2: A write to the shared address (3) with wdata[7]=1 loads the format register from wdata[6:0] and leaves the upper divisor bits unchanged.
- R3: A write to the shared address with wdata[7]=0 loads the upper divisor bits from wdata[3:0] and leaves the format register unchanged.
- R4: A read of address 3 behaves as follows. With `rd_sel_fmt`=1 it returns the format register with bit 7 forced to 1. With `rd_sel_fmt`=0 it returns {4'b0, upper divisor}. When `rd_en` is low, `rdata` is 0.
- R5: The format register fields drive these outputs: bit 6 drives `cfg_sync` (0 asynchronous, 1 synchronous); bits 5:4 drive `cfg_parity`; bit 3 drives `cfg_two_stop`; bit 0 drives `cfg_clk_pol`.
- R6: `cfg_char_code` is {control bit 2, format bits 2:1}. `cfg_char_bits` is 5 to 8 for codes 0 to 3, 9 for code 7, and 8 for the reserved codes 4 to 6.
- R7: Address 2 holds the low divisor byte. `baud_div` is {upper 4 bits, low byte}, and a read of address 2 returns the low byte.
- R8: Control register (address 1) fields are bit 2 for the size high bit and bit 0 for the transmit ninth bit. A write to the data address (0) sets `tx_word` to {staged ninth bit, wdata}, and `tx_load` is high for the single cycle after that write. A later change to the staged ninth bit leaves `tx_word` unchanged.
- R9: A read of address 1 returns {5'b0, size high bit, rx_data[8], transmit ninth bit} and does not assert `rx_pop`. A read of address 0 returns rx_data[7:0] and asserts `rx_pop` in the same cycle.
- R10: With `wr_en` low, nothing changes for any address or data: no register and no output changes, and `tx_load` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rd_sel_fmt | input | 1 | Selects the format register on reads of the shared address |
| rx_data | input | 9 | Oldest received character from the receive buffer |
| rdata | output | 8 | Read data (combinational) |
| rx_pop | output | 1 | Receive buffer advance, high while the data address is read |
| cfg_sync | output | 1 | 0 asynchronous, 1 synchronous |
| cfg_parity | output | 2 | Parity mode |
| cfg_two_stop | output | 1 | Stop-bit select |
| cfg_clk_pol | output | 1 | Clock polarity |
| cfg_char_code | output | 3 | Character-size code |
| cfg_char_bits | output | 4 | Decoded number of data bits |
| baud_div | output | 12 | Baud divisor |
| tx_word | output | 9 | Captured transmit word |
| tx_load | output | 1 | One-cycle pulse after a data write |

## Verification
The bench targets the write steering on the shared address. A design that decodes the wrong bit would corrupt the format fields when software writes the divisor, or the reverse. Reads of the format register must show bit 7 set. A design that returns the stored value would read back 0 in bit 7, because that bit is never stored. Every character-size code, the reserved codes included, is decoded. A wrong decode shows up as a wrong bit count. For the ninth bits, the bench restages the transmit bit after a low-byte write and checks that the captured word does not follow. It also checks that only a read of the data address pops the receive buffer.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef struct packed {
    logic       sync;
    logic [1:0] parity;
    logic       two_stop;
    logic [1:0] size_lo;
    logic       clk_pol;
  } fmt_t;

  localparam logic [7:0] FMT_RESET = 8'h86;

  function automatic logic [3:0] char_bits(input logic [2:0] code);
    if (code == 3'b111)
      return 4'd9;
    else if (code[2])
      return 4'd8;
    else
      return 4'd5 + {2'b00, code[1:0]};
  endfunction

endpackage

// File: rtl/sport_fmt_bank.sv
module sport_fmt_bank
  import sport_pkg::*;
#(
  parameter int BAUD_HI_W = 4,
  parameter int BAUD_LO_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shared_wr,
  input  logic                 baud_lo_wr,
  input  logic [7:0]           wdata,
  output fmt_t                 fmt,
  output logic [BAUD_HI_W-1:0] baud_hi,
  output logic [BAUD_LO_W-1:0] baud_lo
);

  logic fmt_we;
  logic baud_we;

  assign fmt_we  = shared_wr & wdata[7];
  assign baud_we = shared_wr & ~wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt     <= fmt_t'(FMT_RESET[6:0]);
      baud_hi <= '0;
      baud_lo <= '0;
    end else begin
      if (fmt_we)     fmt     <= fmt_t'(wdata[6:0]);
      if (baud_we)    baud_hi <= wdata[BAUD_HI_W-1:0];
      if (baud_lo_wr) baud_lo <= wdata[BAUD_LO_W-1:0];
    end
  end

  p_fmt_steer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_wr && wdata[7]) |=> $stable(baud_hi));

  p_baud_steer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_wr && !wdata[7]) |=> $stable(fmt));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shared_wr && !baud_lo_wr) |=> ($stable(fmt) && $stable(baud_hi) && $stable(baud_lo)));

endmodule

// File: rtl/sport_data_stage.sv
module sport_data_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  output logic          size_hi,
  output logic          tx9,
  output logic [DW:0]   tx_word,
  output logic          tx_load
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_hi <= 1'b0;
      tx9     <= 1'b0;
      tx_word <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= data_wr;
      if (ctl_wr) begin
        size_hi <= wdata[2];
        tx9     <= wdata[0];
      end
      if (data_wr) tx_word <= {tx9, wdata};
    end
  end

  p_tx_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_load && tx_word[DW] == $past(tx9) && tx_word[DW-1:0] == $past(wdata)));

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> (!tx_load && $stable(tx_word)));

endmodule

// File: rtl/sport_rd_mux.sv
module sport_rd_mux
  import sport_pkg::*;
#(
  parameter int              AW        = 2,
  parameter int              BAUD_HI_W = 4,
  parameter int              BAUD_LO_W = 8,
  parameter logic [AW-1:0]   A_DATA    = 0,
  parameter logic [AW-1:0]   A_CTL     = 1,
  parameter logic [AW-1:0]   A_BLO     = 2,
  parameter logic [AW-1:0]   A_SHARED  = 3
) (
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic                 rd_sel_fmt,
  input  fmt_t                 fmt,
  input  logic [BAUD_HI_W-1:0] baud_hi,
  input  logic [BAUD_LO_W-1:0] baud_lo,
  input  logic                 size_hi,
  input  logic                 tx9,
  input  logic [8:0]           rx_data,
  output logic [7:0]           rdata,
  output logic                 rx_pop
);

  logic [7:0] hi_ext;
  logic [7:0] lo_ext;

  always_comb begin
    hi_ext = '0;
    hi_ext[BAUD_HI_W-1:0] = baud_hi;
    lo_ext = '0;
    lo_ext[BAUD_LO_W-1:0] = baud_lo;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_DATA:   rdata = rx_data[7:0];
        A_CTL:    rdata = {5'b0, size_hi, rx_data[8], tx9};
        A_BLO:    rdata = lo_ext;
        default:  rdata = rd_sel_fmt ? {1'b1, fmt} : hi_ext;
      endcase
    end
  end

  assign rx_pop = rd_en && (addr == A_DATA);

  always_comb begin
    if (rd_en && addr == A_SHARED && !rd_sel_fmt)
      a_hi_clear_r4: assert (rdata[7] == 1'b0);
    if (rx_pop)
      a_pop_only_data_r9: assert (addr != A_CTL);
  end

endmodule

// File: rtl/sport_regfile.sv
module sport_regfile
  import sport_pkg::*;
#(
  parameter int            AW        = 2,
  parameter int            BAUD_HI_W = 4,
  parameter int            BAUD_LO_W = 8,
  parameter logic [AW-1:0] A_DATA    = 0,
  parameter logic [AW-1:0] A_CTL     = 1,
  parameter logic [AW-1:0] A_BLO     = 2,
  parameter logic [AW-1:0] A_SHARED  = 3,
  localparam int           DIV_W     = BAUD_HI_W + BAUD_LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  input  logic             rd_sel_fmt,
  input  logic [8:0]       rx_data,
  output logic [7:0]       rdata,
  output logic             rx_pop,
  output logic             cfg_sync,
  output logic [1:0]       cfg_parity,
  output logic             cfg_two_stop,
  output logic             cfg_clk_pol,
  output logic [2:0]       cfg_char_code,
  output logic [3:0]       cfg_char_bits,
  output logic [DIV_W-1:0] baud_div,
  output logic [8:0]       tx_word,
  output logic             tx_load
);

  logic                 data_wr, ctl_wr, blo_wr, shared_wr;
  fmt_t                 fmt;
  logic [BAUD_HI_W-1:0] baud_hi;
  logic [BAUD_LO_W-1:0] baud_lo;
  logic                 size_hi, tx9;

  assign data_wr   = wr_en && addr == A_DATA;
  assign ctl_wr    = wr_en && addr == A_CTL;
  assign blo_wr    = wr_en && addr == A_BLO;
  assign shared_wr = wr_en && addr == A_SHARED;

  sport_fmt_bank #(.BAUD_HI_W(BAUD_HI_W), .BAUD_LO_W(BAUD_LO_W)) u_fmt (
    .clk(clk), .rst_n(rst_n), .shared_wr(shared_wr), .baud_lo_wr(blo_wr),
    .wdata(wdata), .fmt(fmt), .baud_hi(baud_hi), .baud_lo(baud_lo)
  );

  sport_data_stage #(.DW(8)) u_stage (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctl_wr(ctl_wr), .wdata(wdata),
    .size_hi(size_hi), .tx9(tx9), .tx_word(tx_word), .tx_load(tx_load)
  );

  sport_rd_mux #(.AW(AW), .BAUD_HI_W(BAUD_HI_W), .BAUD_LO_W(BAUD_LO_W),
                 .A_DATA(A_DATA), .A_CTL(A_CTL), .A_BLO(A_BLO), .A_SHARED(A_SHARED)) u_rd (
    .rd_en(rd_en), .addr(addr), .rd_sel_fmt(rd_sel_fmt), .fmt(fmt),
    .baud_hi(baud_hi), .baud_lo(baud_lo), .size_hi(size_hi), .tx9(tx9),
    .rx_data(rx_data), .rdata(rdata), .rx_pop(rx_pop)
  );

  assign cfg_sync      = fmt.sync;
  assign cfg_parity    = fmt.parity;
  assign cfg_two_stop  = fmt.two_stop;
  assign cfg_clk_pol   = fmt.clk_pol;
  assign cfg_char_code = {size_hi, fmt.size_lo};
  assign cfg_char_bits = char_bits(cfg_char_code);
  assign baud_div      = {baud_hi, baud_lo};

  p_bits_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_char_bits >= 4'd5 && cfg_char_bits <= 4'd9));

  p_nine_only_code7_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_char_bits == 4'd9) |-> (cfg_char_code == 3'b111));

endmodule

// File: tb/sport_regfile_bench.sv
module sport_regfile_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, rd_sel_fmt = 1'b0;
  logic [7:0]  wdata = '0;
  logic [8:0]  rx_data = '0;
  logic [7:0]  rdata;
  logic        rx_pop, cfg_sync, cfg_two_stop, cfg_clk_pol, tx_load;
  logic [1:0]  cfg_parity;
  logic [2:0]  cfg_char_code;
  logic [3:0]  cfg_char_bits;
  logic [11:0] baud_div;
  logic [8:0]  tx_word;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [6:0] m_fmt;
  logic [3:0] m_bhi;
  logic [7:0] m_blo;
  logic       m_shi, m_tx9, m_load;
  logic [8:0] m_txw;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_regfile u_sport_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rd_sel_fmt(rd_sel_fmt), .rx_data(rx_data), .rdata(rdata),
    .rx_pop(rx_pop), .cfg_sync(cfg_sync), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .cfg_clk_pol(cfg_clk_pol),
    .cfg_char_code(cfg_char_code), .cfg_char_bits(cfg_char_bits),
    .baud_div(baud_div), .tx_word(tx_word), .tx_load(tx_load)
  );

  function automatic int exp_bits(input logic [2:0] c);
    case (c)
      3'd0: return 5;
      3'd1: return 6;
      3'd2: return 7;
      3'd7: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_outs();
    logic [2:0] c;
    c = {m_shi, m_fmt[2:1]};
    chk("R5 sync",   cfg_sync,     m_fmt[6]);
    chk("R5 parity", cfg_parity,   m_fmt[5:4]);
    chk("R5 stop",   cfg_two_stop, m_fmt[3]);
    chk("R5 pol",    cfg_clk_pol,  m_fmt[0]);
    chk("R6 code",   cfg_char_code, c);
    chk("R6 bits",   cfg_char_bits, exp_bits(c));
    chk("R7 div",    baud_div, {m_bhi, m_blo});
    chk("R8 txword", tx_word, m_txw);
    chk("R8 txload", tx_load, m_load);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    addr = a; wdata = d; wr_en = en;
    @(negedge clk);
    wr_en = 1'b0;
    m_load = 1'b0;
    if (en) begin
      case (a)
        2'd0: begin m_txw = {m_tx9, d}; m_load = 1'b1; end
        2'd1: begin m_shi = d[2]; m_tx9 = d[0]; end
        2'd2: m_blo = d;
        2'd3: if (d[7]) m_fmt = d[6:0]; else m_bhi = d[3:0];
      endcase
    end
    check_outs();
  endtask

  task automatic rd(input logic [1:0] a, input logic sel);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd_sel_fmt = sel; rd_en = 1'b1;
    rx_data = 9'($urandom_range(0, 511));
    #1;
    case (a)
      2'd0: e = rx_data[7:0];
      2'd1: e = {5'b0, m_shi, rx_data[8], m_tx9};
      2'd2: e = m_blo;
      default: e = sel ? {1'b1, m_fmt} : {4'b0, m_bhi};
    endcase
    chk(a == 2'd3 ? "R4 rdata" : "R9 rdata", rdata, e);
    chk("R9 pop", rx_pop, a == 2'd0);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_fmt = 7'h06; m_bhi = 0; m_blo = 0; m_shi = 0; m_tx9 = 0; m_txw = 0; m_load = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 txload", tx_load, 0);
    chk("R1 div", baud_div, 0);
    chk("R1 code", cfg_char_code, 3);
    chk("R1 bits", cfg_char_bits, 8);
    rst_n = 1'b1;
    rd_en = 1'b1; addr = 2'd3; rd_sel_fmt = 1'b1; #1;
    chk("R1 fmt read", rdata, 8'h86);
    rd_en = 1'b0; #1;
    chk("R4 idle rdata", rdata, 0);
    check_outs();

    // R3 then R2 steering on the shared address
    wr(2'd3, 8'h7A, 1'b1);
    rd(2'd3, 1'b0);
    rd(2'd3, 1'b1);
    wr(2'd3, 8'hC5, 1'b1);
    rd(2'd3, 1'b1);
    rd(2'd3, 1'b0);
    wr(2'd2, 8'h9C, 1'b1);
    rd(2'd2, 1'b0);

    // R6 every size code, including reserved ones
    for (int k = 0; k < 8; k++) begin
      wr(2'd1, {5'b0, 3'(k >> 2)}, 1'b1);
      wr(2'd3, {1'b1, 4'b0, 2'(k & 3), 1'b0}, 1'b1);
    end

    // R8 ninth bit staging and hold
    wr(2'd1, 8'h01, 1'b1);
    wr(2'd0, 8'h3C, 1'b1);
    chk("R8 ninth", tx_word[8], 1);
    wr(2'd1, 8'h00, 1'b1);
    chk("R8 hold", tx_word, 9'h13C);

    // R9 control read does not pop, data read pops
    rd(2'd1, 1'b0);
    rd(2'd0, 1'b0);

    // R10 writes without strobe
    for (int k = 0; k < 4; k++) wr(2'(k), 8'hFF, 1'b0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 1) == 0)
        wr(2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)), 1'($urandom_range(0, 3) != 0));
      else
        rd(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule